// File: doc/BRIEF.md
# Latched Input-Change Interrupt Controller

This block watches two groups of four port pins and tells a host when any pin used as an input has moved away from the level the host last saw. Each pin passes through a synchronizer and a short stability filter. Each group keeps a snapshot of its pins and a set of sticky change flags. The active-low interrupt line is pulled low while any flag in either group is set. It stays low until the host reads the group that caused it.

The serial slave logic in front of this block requests a group read at the moment it acknowledges the read address. The controller accepts that request, captures the filtered pins of the chosen group as the new snapshot, clears only that group's flags, and returns the captured value on a valid/ready output. After the read, changes are compared against the new snapshot. A per-pin mask keeps a pin quiet while it is being turned from an output into an input. When the mask is released, the pin's snapshot is refreshed, so a change made while masked does not raise a late interrupt.

Back-pressure rules: a read request is accepted on a cycle where `rd_req_valid_i` and `rd_req_ready_o` are both high. `rd_req_ready_o` is high whenever no returned value is waiting, or the waiting value is being taken in the same cycle. While `snap_valid_o` is high and `snap_ready_i` is low, `snap_data_o` holds its value.

Top module: `icd_change_irq`

## Requirements
- R1: After reset, `int_n_o` is high, all change flags are clear, `snap_valid_o` is low and `rd_req_ready_o` is high.
- R2: A direction bit of 1 marks its pin as an input. A change on such a pin (mask bit 0) sets that pin's flag and drives `int_n_o` low.
- R3: A pin whose direction bit is 0 (output) never sets a flag, whatever level it shows.
- R4: A mask bit of 1 stops its pin from setting a flag. A mask bit of 0 allows it.
- R5: Once set, a flag stays set even if the pin returns to its snapshot level, until its group is read.
- R6: A read with `rd_req_grp_i` = 0 clears only group A's flags. A read with `rd_req_grp_i` = 1 clears only group B's flags.
- R7: On an accepted read, the filtered pins of the chosen group become that group's snapshot and are returned on `snap_data_o` in the next cycle. The group's flags are clear from that cycle on, and later changes are judged against the new snapshot.
- R8: A pin change must be seen at the synchronizer output for `STABLE_CYC` consecutive clocks before it counts. A single-clock pulse sets no flag.
- R9: When a mask bit goes from 1 to 0, that pin's snapshot takes the pin's present filtered level, and no flag is raised for a change made while masked.
- R10: `int_n_o` is low exactly when at least one flag in either group is set.
- R11: `rd_req_ready_o` = !`snap_valid_o` || `snap_ready_i`. While `snap_valid_o` is high and `snap_ready_i` is low, `snap_valid_o` and `snap_data_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a_i | input | GRP_W | Asynchronous pin levels, group A |
| pin_b_i | input | GRP_W | Asynchronous pin levels, group B |
| dir_a_i | input | GRP_W | Direction per pin, group A (1 = input) |
| dir_b_i | input | GRP_W | Direction per pin, group B (1 = input) |
| mask_a_i | input | GRP_W | Interrupt mask per pin, group A (1 = disabled) |
| mask_b_i | input | GRP_W | Interrupt mask per pin, group B (1 = disabled) |
| rd_req_valid_i | input | 1 | Group read request, raised at read-address acknowledge |
| rd_req_grp_i | input | 1 | Group to read (0 = A, 1 = B) |
| rd_req_ready_o | output | 1 | Read request can be accepted |
| snap_valid_o | output | 1 | Returned snapshot is valid |
| snap_data_o | output | GRP_W | Returned snapshot value |
| snap_ready_i | input | 1 | Host takes the returned snapshot |
| int_n_o | output | 1 | Latched interrupt, active low |

## Verification
The checker tests on every cycle that a flag rises only on a pin that was an unmasked input in the cycle before. It also tests that a read of one group never clears the other group's flags, that an accepted read leaves that group's flags clear and returns the filtered pins, and that a held output stays stable under back-pressure. Other behaviours can only be shown by the bench's scenarios: the pin filter's pulse-width threshold, a flag that stays latched after the pin returns, the absence of a late interrupt after unmasking, and new changes being judged against the new snapshot. Each of these depends on a sequence of pin activity rather than on a relation within one cycle.

// File: rtl/icd_pkg.sv
package icd_pkg;
  localparam int N_GRP = 2;
  typedef enum logic {GRP_A = 1'b0, GRP_B = 1'b1} grp_sel_e;
endpackage

// File: rtl/icd_pin_filter.sv
// Synchronizes asynchronous pins and accepts a new level only after it has
// been held at the synchronizer output for STABLE_CYC consecutive clocks.
module icd_pin_filter #(
  parameter int W           = 4,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] filt_o
);
  localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;

  logic [W-1:0] sync_q [SYNC_STAGES];
  logic [W-1:0] sync_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign sync_last = sync_q[SYNC_STAGES-1];

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        lvl_q <= 1'b0;
      end else if (sync_last[b] != lvl_q) begin
        if (cnt_q == CW'(STABLE_CYC - 1)) begin
          lvl_q <= sync_last[b];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end

    assign filt_o[b] = lvl_q;
  end
endmodule

// File: rtl/icd_group_tracker.sv
// Snapshot and sticky change flags for one port group.
module icd_group_tracker #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] filt_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] mask_i,
  input  logic         take_i,
  output logic [W-1:0] snap_o,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] snap_q, flag_q, mask_q;
  logic [W-1:0] unmask, arm, diff;

  assign unmask = mask_q & ~mask_i;
  assign arm    = dir_i & ~mask_i & ~mask_q;
  assign diff   = filt_i ^ snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      mask_q <= mask_i;
      if (take_i) begin
        snap_q <= filt_i;
        flag_q <= '0;
      end else begin
        snap_q <= (snap_q & ~unmask) | (filt_i & unmask);
        flag_q <= flag_q | (diff & arm);
      end
    end
  end

  assign snap_o = snap_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/icd_read_port.sv
// Accepts group read requests and returns the captured value on valid/ready.
module icd_read_port #(
  parameter int W     = 4,
  parameter int N_GRP = 2,
  localparam int GW   = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid_i,
  input  logic [GW-1:0]           req_grp_i,
  output logic                    req_ready_o,
  input  logic [N_GRP-1:0][W-1:0] filt_i,
  output logic [N_GRP-1:0]        take_o,
  output logic                    out_valid_o,
  output logic [W-1:0]            out_data_o,
  input  logic                    out_ready_i
);
  logic         val_q;
  logic [W-1:0] dat_q;
  logic         accept;

  assign req_ready_o = !val_q || out_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  for (genvar g = 0; g < N_GRP; g++) begin : g_take
    assign take_o[g] = accept && (req_grp_i == GW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= 1'b0;
      dat_q <= '0;
    end else if (accept) begin
      val_q <= 1'b1;
      dat_q <= filt_i[req_grp_i];
    end else if (out_ready_i) begin
      val_q <= 1'b0;
    end
  end

  assign out_valid_o = val_q;
  assign out_data_o  = dat_q;
endmodule

// File: rtl/icd_change_irq.sv
module icd_change_irq
  import icd_pkg::*;
#(
  parameter int GRP_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] pin_a_i,
  input  logic [GRP_W-1:0] pin_b_i,
  input  logic [GRP_W-1:0] dir_a_i,
  input  logic [GRP_W-1:0] dir_b_i,
  input  logic [GRP_W-1:0] mask_a_i,
  input  logic [GRP_W-1:0] mask_b_i,
  input  logic             rd_req_valid_i,
  input  logic             rd_req_grp_i,
  output logic             rd_req_ready_o,
  output logic             snap_valid_o,
  output logic [GRP_W-1:0] snap_data_o,
  input  logic             snap_ready_i,
  output logic             int_n_o
);
  logic [N_GRP-1:0][GRP_W-1:0] pins, dirs, masks, filt, snap, flag;
  logic [N_GRP-1:0]            take;
  grp_sel_e                    grp_sel;

  assign pins[GRP_A]  = pin_a_i;
  assign pins[GRP_B]  = pin_b_i;
  assign dirs[GRP_A]  = dir_a_i;
  assign dirs[GRP_B]  = dir_b_i;
  assign masks[GRP_A] = mask_a_i;
  assign masks[GRP_B] = mask_b_i;
  assign grp_sel      = grp_sel_e'(rd_req_grp_i);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    icd_pin_filter #(
      .W(GRP_W), .SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STABLE_CYC)
    ) u_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(pins[g]), .filt_o(filt[g])
    );

    icd_group_tracker #(.W(GRP_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .filt_i(filt[g]), .dir_i(dirs[g]),
      .mask_i(masks[g]), .take_i(take[g]), .snap_o(snap[g]), .flag_o(flag[g])
    );
  end

  icd_read_port #(.W(GRP_W), .N_GRP(N_GRP)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(rd_req_valid_i), .req_grp_i(grp_sel), .req_ready_o(rd_req_ready_o),
    .filt_i(filt), .take_o(take),
    .out_valid_o(snap_valid_o), .out_data_o(snap_data_o), .out_ready_i(snap_ready_i)
  );

  assign int_n_o = ~(|flag);

  // Named taps for the bound checker.
  logic [GRP_W-1:0] flag_a, flag_b, filt_a, filt_b;
  assign flag_a = flag[GRP_A];
  assign flag_b = flag[GRP_B];
  assign filt_a = filt[GRP_A];
  assign filt_b = filt[GRP_B];
endmodule

// File: rtl/icd_change_irq_chk.sv
module icd_change_irq_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] dir_a,
  input logic [W-1:0] dir_b,
  input logic [W-1:0] mask_a,
  input logic [W-1:0] mask_b,
  input logic [W-1:0] flag_a,
  input logic [W-1:0] flag_b,
  input logic [W-1:0] filt_a,
  input logic [W-1:0] filt_b,
  input logic         req_valid,
  input logic         req_grp,
  input logic         req_ready,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_ready,
  input logic         int_n
);
  logic acc_a, acc_b;
  assign acc_a = req_valid && req_ready && !req_grp;
  assign acc_b = req_valid && req_ready && req_grp;

  // R2 R3 R4: a new flag bit needs an unmasked input pin the cycle before
  p_flag_src_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_a & ~$past(flag_a) & ~$past(dir_a & ~mask_a)) == '0));
  p_flag_src_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_b & ~$past(flag_b) & ~$past(dir_b & ~mask_b)) == '0));

  // R6: reading one group never drops flags of the other
  p_iso_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_b |=> (($past(flag_a) & ~flag_a) == '0));
  p_iso_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_a |=> (($past(flag_b) & ~flag_b) == '0));

  // R7: accepted read clears the group and returns its filtered pins
  p_read_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_a |=> (flag_a == '0) && out_valid && (out_data == $past(filt_a)));
  p_read_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_b |=> (flag_b == '0) && out_valid && (out_data == $past(filt_b)));

  // R5: interrupt stays low unless a read is accepted
  p_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_n && !req_valid) |=> !int_n);

  // R11: held output stays stable under back-pressure
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
endmodule

bind icd_change_irq icd_change_irq_chk #(.W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .dir_a(dir_a_i), .dir_b(dir_b_i), .mask_a(mask_a_i), .mask_b(mask_b_i),
  .flag_a(flag_a), .flag_b(flag_b), .filt_a(filt_a), .filt_b(filt_b),
  .req_valid(rd_req_valid_i), .req_grp(rd_req_grp_i), .req_ready(rd_req_ready_o),
  .out_valid(snap_valid_o), .out_data(snap_data_o), .out_ready(snap_ready_i),
  .int_n(int_n_o)
);

// File: tb/tb_icd_change_irq.sv
`timescale 1ns/1ps
module tb_icd_change_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_a = '0, pin_b = '0, dir_a = '0, dir_b = '0, mask_a = '0, mask_b = '0;
  logic       rd_req_valid = 1'b0, rd_req_grp = 1'b0, snap_ready = 1'b0;
  logic       rd_req_ready, snap_valid, int_n;
  logic [3:0] snap_data;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  icd_change_irq dut (
    .clk(clk), .rst_n(rst_n), .pin_a_i(pin_a), .pin_b_i(pin_b),
    .dir_a_i(dir_a), .dir_b_i(dir_b), .mask_a_i(mask_a), .mask_b_i(mask_b),
    .rd_req_valid_i(rd_req_valid), .rd_req_grp_i(rd_req_grp), .rd_req_ready_o(rd_req_ready),
    .snap_valid_o(snap_valid), .snap_data_o(snap_data), .snap_ready_i(snap_ready),
    .int_n_o(int_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic do_read(input logic g, output logic [3:0] d);
    @(negedge clk);
    rd_req_valid = 1'b1; rd_req_grp = g; snap_ready = 1'b0;
    @(negedge clk);
    rd_req_valid = 1'b0;
    d = snap_data;
    snap_ready = 1'b1;
    @(negedge clk);
    snap_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 int_n", int_n, 1);
    chk("R1 snap_valid", snap_valid, 0);
    chk("R1 rd_req_ready", rd_req_ready, 1);
  endtask

  task automatic t_input_change();
    logic [3:0] d;
    dir_a = 4'hF; dir_b = 4'hF;
    pin_a = 4'b0001;
    settle();
    chk("R2 input change int_n", int_n, 0);
    chk("R10 flag drives int", int_n, 0);
    do_read(1'b0, d);
    chk("R7 read data A", d, 4'b0001);
    chk("R7 release after read", int_n, 1);
  endtask

  task automatic t_output_no_int();
    dir_a = 4'h0; dir_b = 4'h0;
    pin_a = 4'b0110; pin_b = 4'b1001;
    settle();
    chk("R3 output pins quiet", int_n, 1);
    pin_a = 4'b0001; pin_b = 4'b0000;
    settle();
    dir_a = 4'hF; dir_b = 4'hF;
    settle();
    chk("R3 back to input quiet", int_n, 1);
  endtask

  task automatic t_mask_and_clear();
    logic [3:0] d;
    mask_b = 4'b0100;
    pin_b = 4'b0100;
    settle();
    chk("R4 masked pin quiet", int_n, 1);
    mask_b = 4'b0000;
    settle();
    chk("R9 no late interrupt", int_n, 1);
    pin_b = 4'b0000;
    settle();
    chk("R9 judged on refreshed snapshot", int_n, 0);
    do_read(1'b1, d);
    chk("R7 read data B", d, 4'b0000);
    chk("R7 release B", int_n, 1);
  endtask

  task automatic t_latched();
    logic [3:0] d;
    pin_a = 4'b0011;
    settle();
    chk("R5 set", int_n, 0);
    pin_a = 4'b0001;
    settle();
    chk("R5 still latched after return", int_n, 0);
    do_read(1'b0, d);
    chk("R5 cleared by read", int_n, 1);
  endtask

  task automatic t_isolation();
    logic [3:0] d;
    pin_a = 4'b1001; pin_b = 4'b1000;
    settle();
    chk("R6 both set", int_n, 0);
    do_read(1'b0, d);
    chk("R6 A data", d, 4'b1001);
    chk("R6 B flag survives A read", int_n, 0);
    do_read(1'b1, d);
    chk("R6 B data", d, 4'b1000);
    chk("R6 all clear", int_n, 1);
  endtask

  task automatic t_glitch();
    logic [3:0] d;
    @(negedge clk); pin_a = 4'b1011;
    @(negedge clk); pin_a = 4'b1001;
    settle();
    chk("R8 one-clock pulse ignored", int_n, 1);
    @(negedge clk); pin_a = 4'b1011;
    repeat (3) @(negedge clk);
    pin_a = 4'b1001;
    settle();
    chk("R8 sustained pulse latched", int_n, 0);
    do_read(1'b0, d);
    chk("R8 data after pulse", d, 4'b1001);
  endtask

  task automatic t_backpressure();
    logic [3:0] d;
    @(negedge clk);
    rd_req_valid = 1'b1; rd_req_grp = 1'b1; snap_ready = 1'b0;
    @(negedge clk);
    rd_req_valid = 1'b0;
    chk("R11 valid", snap_valid, 1);
    chk("R11 ready low while held", rd_req_ready, 0);
    chk("R11 data", snap_data, 4'b1000);
    pin_b = 4'b0000;
    settle();
    chk("R11 data stable", snap_data, 4'b1000);
    chk("R11 valid held", snap_valid, 1);
    chk("R7 change vs new snapshot", int_n, 0);
    snap_ready = 1'b1;
    #0;
    chk("R11 ready follows out ready", rd_req_ready, 1);
    @(negedge clk);
    snap_ready = 1'b0;
    chk("R11 drained", snap_valid, 0);
    do_read(1'b1, d);
    chk("R11 next read data", d, 4'b0000);
    chk("R7 release", int_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_input_change();
    t_output_no_int();
    t_mask_and_clear();
    t_latched();
    t_isolation();
    t_glitch();
    t_backpressure();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule